// File: doc/BRIEF.md
# Collision Jam and Backoff Controller

This block sits beside a half-duplex Ethernet transmitter and takes over when the medium reports a collision. It forces the transmit data to a run of ones for a fixed number of bit times, holding that jam back while the preamble is still being sent. When the jam ends it aborts the current attempt. It then either schedules a retry after a random whole number of slot times or gives the frame up.

The frame is given up in two cases. The first is a collision after the first slot time of the attempt, which is reported as a late collision. The second is a run of collisions that reaches the attempt limit, which is reported as an excessive-retry error. The random slot count uses truncated binary exponential backoff, drawn from a free-running internal LFSR. The end of the backoff is signalled by a single pulse, so that the inter-packet gap timer can run before the frame is sent again.

Top module: `coll_backoff_ctrl`

## Requirements
- R1: After a collision sampled while the preamble is off, `jam_sel` rises in the next cycle and stays high for exactly JAM_BITS bit ticks. In the cycle after the jam ends, `tx_abort` is high for one cycle.
- R2: After a collision sampled while `preamble_on` is high, `jam_sel` stays low for as long as `preamble_on` stays high. The jam starts in the cycle after `preamble_on` is first sampled low, and then lasts JAM_BITS ticks as in R1.
- R3: A collision with `bits_sent` below SLOT_BITS (the boundary value SLOT_BITS-1 included) ends with `retry_go` pulsing high for one cycle. Neither error flag is raised.
- R4: On the n-th consecutive collision, the time from `tx_abort` to `retry_go` is k*SLOT_BITS ticks plus one cycle. k is an integer with 0 <= k < 2^min(n,BACKOFF_CAP).
- R5: A collision with `bits_sent` at or above SLOT_BITS raises `late_col_err` together with `tx_abort`, and no `retry_go` follows.
- R6: The MAX_TRIES-th consecutive collision raises `retry_limit_err` together with `tx_abort`, and no `retry_go` follows.
- R7: The attempt count returns to zero after a give-up (late collision or retry limit) and after a `tx_done` pulse. The next collision is then treated as the first one, so k < 2.
- R8: `col_det` has no effect while a jam, a preamble hold or a backoff is in progress. No new jam starts, and the backoff still ends with `retry_go`.
- R9: While `rst_n` is low, every output is low at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_tick | input | 1 | One pulse per bit time |
| col_det | input | 1 | Collision detected on the medium |
| preamble_on | input | 1 | Transmitter is sending the preamble |
| bits_sent | input | CNT_W | Bits sent so far in the current attempt |
| tx_done | input | 1 | Frame sent without collision |
| jam_sel | output | 1 | Select all-ones jam data |
| tx_abort | output | 1 | One-cycle pulse that ends the current attempt |
| retry_go | output | 1 | One-cycle pulse at the end of the backoff |
| late_col_err | output | 1 | Pulse with `tx_abort` for a late collision |
| retry_limit_err | output | 1 | Pulse with `tx_abort` when the attempt limit is reached |

## Verification
The assertions assume the following about the inputs:
- `bits_sent` is valid in the cycle a collision is sampled.
- Once a collision has been seen during the preamble, `preamble_on` eventually falls.
- `col_det` only starts a new sequence while the block is idle.

The stimulus keeps to this. It drives single-cycle collision pulses, holds `bit_tick` high so that one tick equals one cycle, and lowers the preamble flag by itself. It sweeps every attempt number from one up to the limit against a small configuration, and computes the expected jam length, slot multiple and slot bound arithmetically for each attempt.

// File: rtl/coll_pkg.sv
// Shared types for the collision jam and backoff controller.
package coll_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PRE_HOLD,
        ST_JAM,
        ST_BACKOFF
    } coll_state_e;
endpackage

// File: rtl/coll_lfsr.sv
// Free-running Galois LFSR that supplies random bits for the slot draw.
// Assumes TAPS is a maximal-length polynomial and SEED is nonzero.
module coll_lfsr #(
    parameter int          LFSR_W = 16,
    parameter logic [LFSR_W-1:0] TAPS = 16'hB400,
    parameter logic [LFSR_W-1:0] SEED = 16'h1ACE
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [LFSR_W-1:0] rnd
);
    // Advance one step every clock cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) rnd <= SEED;
        else        rnd <= (rnd >> 1) ^ (rnd[0] ? TAPS : '0);
    end

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rnd != '0); // R4
endmodule

// File: rtl/coll_slot_draw.sv
// Turns random bits into a slot count below 2^min(n, CAP) for attempt n.
// Assumes try_num is at least 1 whenever the result is used.
module coll_slot_draw #(
    parameter int CAP    = 10,
    parameter int LFSR_W = 16,
    parameter int TRY_W  = 5
) (
    input  logic [TRY_W-1:0]  try_num,
    input  logic [LFSR_W-1:0] rnd,
    output logic [CAP-1:0]    slots
);
    // Bit i of the count is enabled only once the attempt number passes i.
    for (genvar i = 0; i < CAP; i++) begin : g_bit
        assign slots[i] = rnd[i] & (try_num > TRY_W'(i));
    end
endmodule

// File: rtl/coll_backoff_timer.sv
// Counts a loaded number of slot times in bit ticks, then pulses done.
// Assumes load arrives only while the timer is idle.
module coll_backoff_timer #(
    parameter int SLOT_BITS = 512,
    parameter int SLOT_W    = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [SLOT_W-1:0] slots,
    input  logic              bit_tick,
    output logic              done,
    output logic              busy
);
    localparam int BIT_W = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1;
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(SLOT_BITS - 1);

    logic [SLOT_W-1:0] slot_left;
    logic [BIT_W-1:0]  bit_cnt;

    // Load the count, then step bits and slots down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            done      <= 1'b0;
            slot_left <= '0;
            bit_cnt   <= '0;
        end else begin
            done <= 1'b0;
            if (load) begin
                busy      <= 1'b1;
                slot_left <= slots;
                bit_cnt   <= '0;
            end else if (busy) begin
                if (slot_left == '0) begin
                    done <= 1'b1;
                    busy <= 1'b0;
                end else if (bit_tick) begin
                    if (bit_cnt == BIT_LAST) begin
                        bit_cnt   <= '0;
                        slot_left <= slot_left - 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
            end
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R3
    AST_SLOTS_NEVER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !load) |=> (slot_left <= $past(slot_left))); // R4
endmodule

// File: rtl/coll_backoff_ctrl.sv
// Collision jam and backoff controller for a half-duplex transmitter.
// It jams for JAM_BITS ticks (after the preamble if needed), then retries
// after a random number of slots or gives the frame up.
// Assumes bits_sent is valid when col_det is sampled high.
module coll_backoff_ctrl
    import coll_pkg::*;
#(
    parameter int JAM_BITS    = 32,
    parameter int SLOT_BITS   = 512,
    parameter int MAX_TRIES   = 16,
    parameter int BACKOFF_CAP = 10,
    parameter int LFSR_W      = 16,
    parameter int CNT_W       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             col_det,
    input  logic             preamble_on,
    input  logic [CNT_W-1:0] bits_sent,
    input  logic             tx_done,
    output logic             jam_sel,
    output logic             tx_abort,
    output logic             retry_go,
    output logic             late_col_err,
    output logic             retry_limit_err
);
    localparam int JAM_W = (JAM_BITS > 1) ? $clog2(JAM_BITS) : 1;
    localparam int TRY_W = $clog2(MAX_TRIES + 1);
    localparam logic [JAM_W-1:0] JAM_LAST  = JAM_W'(JAM_BITS - 1);
    localparam logic [TRY_W-1:0] TRY_LAST  = TRY_W'(MAX_TRIES - 1);
    localparam logic [CNT_W-1:0] LATE_FROM = CNT_W'(SLOT_BITS);

    coll_state_e         state;
    logic [JAM_W-1:0]    jam_cnt;
    logic [TRY_W-1:0]    tries;
    logic                late_q;
    logic                jam_end;
    logic                start_backoff;
    logic [TRY_W-1:0]    next_try;
    logic [LFSR_W-1:0]   rnd;
    logic [BACKOFF_CAP-1:0] slots;
    logic                timer_busy;

    assign jam_sel       = (state == ST_JAM);
    assign jam_end       = jam_sel && bit_tick && (jam_cnt == JAM_LAST);
    assign next_try      = tries + 1'b1;
    assign start_backoff = jam_end && !late_q && (tries != TRY_LAST);

    coll_lfsr #(.LFSR_W(LFSR_W)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .rnd   (rnd)
    );

    coll_slot_draw #(.CAP(BACKOFF_CAP), .LFSR_W(LFSR_W), .TRY_W(TRY_W)) u_draw (
        .try_num (next_try),
        .rnd     (rnd),
        .slots   (slots)
    );

    coll_backoff_timer #(.SLOT_BITS(SLOT_BITS), .SLOT_W(BACKOFF_CAP)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start_backoff),
        .slots    (slots),
        .bit_tick (bit_tick),
        .done     (retry_go),
        .busy     (timer_busy)
    );

    // Sequence state, jam length, attempt count and abort pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state           <= ST_IDLE;
            jam_cnt         <= '0;
            tries           <= '0;
            late_q          <= 1'b0;
            tx_abort        <= 1'b0;
            late_col_err    <= 1'b0;
            retry_limit_err <= 1'b0;
        end else begin
            tx_abort        <= 1'b0;
            late_col_err    <= 1'b0;
            retry_limit_err <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (tx_done) tries <= '0;
                    if (col_det) begin
                        jam_cnt <= '0;
                        if (preamble_on) begin
                            late_q <= 1'b0;
                            state  <= ST_PRE_HOLD;
                        end else begin
                            late_q <= (bits_sent >= LATE_FROM);
                            state  <= ST_JAM;
                        end
                    end
                end
                ST_PRE_HOLD: begin
                    if (!preamble_on) state <= ST_JAM;
                end
                ST_JAM: begin
                    if (jam_end) begin
                        tx_abort <= 1'b1;
                        if (late_q) begin
                            late_col_err <= 1'b1;
                            tries        <= '0;
                            state        <= ST_IDLE;
                        end else if (tries == TRY_LAST) begin
                            retry_limit_err <= 1'b1;
                            tries           <= '0;
                            state           <= ST_IDLE;
                        end else begin
                            tries <= next_try;
                            state <= ST_BACKOFF;
                        end
                    end else if (bit_tick) begin
                        jam_cnt <= jam_cnt + 1'b1;
                    end
                end
                ST_BACKOFF: begin
                    if (retry_go) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_ABORT_AFTER_JAM: assert property (@(posedge clk) disable iff (!rst_n)
        tx_abort |-> $past(jam_sel)); // R1
    AST_PRE_HOLDS_JAM: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRE_HOLD && preamble_on) |=> !jam_sel); // R2
    AST_RETRY_IN_BACKOFF: assert property (@(posedge clk) disable iff (!rst_n)
        retry_go |-> (state == ST_BACKOFF)); // R3
    AST_LATE_WITH_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        late_col_err |-> (tx_abort && !retry_limit_err && !timer_busy)); // R5
    AST_LIMIT_WITH_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        retry_limit_err |-> (tx_abort && !timer_busy)); // R6
    AST_TRIES_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        tries < TRY_W'(MAX_TRIES)); // R6
    AST_BUSY_NO_JAM: assert property (@(posedge clk) disable iff (!rst_n)
        timer_busy |-> !jam_sel); // R8
endmodule

// File: tb/coll_backoff_ctrl_bench.sv
`timescale 1ns/1ps
module coll_backoff_ctrl_bench;
    localparam int J   = 4;
    localparam int S   = 8;
    localparam int MT  = 16;
    localparam int CAP = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_tick = 1'b1;
    logic        col_det = 1'b0;
    logic        preamble_on = 1'b0;
    logic [15:0] bits_sent = '0;
    logic        tx_done = 1'b0;
    logic        jam_sel, tx_abort, retry_go, late_col_err, retry_limit_err;

    int errs = 0;
    int checks = 0;
    int cyc = 0;
    bit ended = 1'b0;

    always #2.5 clk = ~clk;

    coll_backoff_ctrl #(.JAM_BITS(J), .SLOT_BITS(S), .MAX_TRIES(MT),
                        .BACKOFF_CAP(CAP), .LFSR_W(16), .CNT_W(16)) u_coll_backoff_ctrl (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .col_det(col_det),
        .preamble_on(preamble_on), .bits_sent(bits_sent), .tx_done(tx_done),
        .jam_sel(jam_sel), .tx_abort(tx_abort), .retry_go(retry_go),
        .late_col_err(late_col_err), .retry_limit_err(retry_limit_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic collide(input int bits, input bit pre);
        @(negedge clk);
        col_det = 1'b1; bits_sent = 16'(bits); preamble_on = pre;
        @(negedge clk);
        col_det = 1'b0;
    endtask

    // Called with jam_sel expected high; ends on the cycle tx_abort shows.
    task automatic measure_jam(input string req);
        int n = 0;
        while (jam_sel && n < 100) begin
            n++;
            @(negedge clk);
        end
        chk(n == J, {req, " jam length"}, n, J);
        chk(tx_abort == 1'b1, "R1 abort after jam", int'(tx_abort), 1);
    endtask

    task automatic measure_backoff(input int tries, input bit poke, input string req);
        int d = 0;
        int k;
        int lim;
        bit jam_seen = 1'b0;
        bit abort_seen = 1'b0;
        while (!retry_go && d < 20000) begin
            @(negedge clk);
            d++;
            if (tx_abort) abort_seen = 1'b1;
            if (jam_sel) jam_seen = 1'b1;
            if (poke && d == 3 && !retry_go) col_det = 1'b1;
            if (d == 4) col_det = 1'b0;
        end
        col_det = 1'b0;
        chk(!abort_seen, "R1 abort is one cycle", int'(abort_seen), 0);
        chk(d >= 1 && ((d - 1) % S) == 0, {req, " slot multiple"}, d - 1, ((d - 1) / S) * S);
        k   = (d - 1) / S;
        lim = 1 << ((tries < CAP) ? tries : CAP);
        chk(k < lim, {req, " slot bound"}, k, lim - 1);
        if (poke) chk(!jam_seen, "R8 collision ignored in backoff", int'(jam_seen), 0);
        @(negedge clk);
        chk(retry_go == 1'b0, "R3 retry_go one cycle", int'(retry_go), 0);
    endtask

    task automatic no_retry_window(input string req);
        bit seen = 1'b0;
        repeat (30) begin
            @(negedge clk);
            if (retry_go || jam_sel) seen = 1'b1;
        end
        chk(!seen, {req, " no retry after give-up"}, int'(seen), 0);
    endtask

    task automatic early_attempt(input int bits, input int tries, input bit poke, input string req);
        collide(bits, 1'b0);
        chk(jam_sel == 1'b1, "R1 jam starts next cycle", int'(jam_sel), 1);
        measure_jam("R1");
        chk(!late_col_err && !retry_limit_err, "R3 no error flag",
            int'({late_col_err, retry_limit_err}), 0);
        measure_backoff(tries, poke, req);
    endtask

    // Watchdog: an overrun is a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !ended) begin
            ended = 1'b1;
            errs++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({jam_sel, tx_abort, retry_go, late_col_err, retry_limit_err} == 5'b0,
            "R9 reset outputs", int'({jam_sel, tx_abort, retry_go, late_col_err, retry_limit_err}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3/R4 sweep of every attempt below the limit; R8 poke on attempt 2.
        for (int n = 1; n < MT; n++) begin
            early_attempt((n == 1) ? 0 : S - 1, n, n == 2, "R4");
        end

        // R6: the limit-reaching collision gives up.
        collide(S - 1, 1'b0);
        measure_jam("R1");
        chk(retry_limit_err == 1'b1, "R6 limit flag", int'(retry_limit_err), 1);
        chk(late_col_err == 1'b0, "R6 no late flag", int'(late_col_err), 0);
        no_retry_window("R6");

        // R7: count cleared after give-up, then after tx_done.
        early_attempt(0, 1, 1'b0, "R7 after limit");
        early_attempt(3, 2, 1'b0, "R4 second attempt");
        @(negedge clk); tx_done = 1'b1;
        @(negedge clk); tx_done = 1'b0;
        early_attempt(5, 1, 1'b0, "R7 after tx_done");

        // R5: late collision at the exact boundary.
        collide(S, 1'b0);
        measure_jam("R1");
        chk(late_col_err == 1'b1, "R5 late flag", int'(late_col_err), 1);
        chk(retry_limit_err == 1'b0, "R5 no limit flag", int'(retry_limit_err), 0);
        no_retry_window("R5");
        early_attempt(1, 1, 1'b0, "R7 after late");

        // R2: collision during preamble waits for its end.
        @(negedge clk);
        col_det = 1'b1; bits_sent = 16'd0; preamble_on = 1'b1;
        @(negedge clk);
        col_det = 1'b0;
        for (int i = 0; i < 5; i++) begin
            chk(jam_sel == 1'b0, "R2 no jam during preamble", int'(jam_sel), 0);
            @(negedge clk);
        end
        preamble_on = 1'b0;
        @(negedge clk);
        chk(jam_sel == 1'b1, "R2 jam after preamble", int'(jam_sel), 1);
        measure_jam("R2");
        measure_backoff(2, 1'b0, "R4 after preamble");

        if (!ended) begin
            ended = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule